// File: doc/BRIEF.md
# Protected-Write Clock Prescaler

This block divides the system clock by a power of two and presents the result as a single-cycle clock-enable pulse. Downstream synchronous logic qualifies its registers with this pulse instead of receiving a gated clock. The division setting lives in an 8-bit register reached through a simple write strobe, write data and read data interface.

The divide setting is guarded against stray writes. First, software writes a value with only the top bit set. This opens a short change window, and the top bit reads back as one while the window is open. Second, software writes the new setting with the top bit clear. The window closes by itself four clock cycles after it opens, and any setting written outside it is discarded. A strap input picks the setting loaded at reset: no division, or division by eight.

When a new setting is accepted, the internal divide counter starts again from zero. The first pulse at the new rate therefore comes a full period later, with no shortened period.

Top module: `pclk_guard_div`

## Requirements
- R1: The read data shows the change-enable flag in bit 7, zeros in bits 6 to 4, and the active select code in bits 3 to 0.
- R2: The change-enable flag is set only by a write of exactly 8'h80 (bit 7 one, bits 6 to 0 zero) while the flag is clear. Any other write leaves it clear.
- R3: Once set by the write sampled at clock edge k, the flag reads one through edge k+3 and is cleared by edge k+4 on its own. A select write is accepted at edges k+1 to k+4 and rejected from edge k+5 on.
- R4: Writing 8'h80 again while the flag is set neither clears the flag nor restarts the four-cycle window.
- R5: A write with bit 7 at zero loads bits 3 to 0 into the select code only while the flag is set, and it clears the flag at once. Bits 6 to 4 of such a write are ignored. Without the flag set, the select code keeps its value.
- R6: At reset the select code loads 4'b0000 when the strap input is 0 and 4'b0011 (divide by eight) when it is 1. The flag resets to zero.
- R7: After a successful unlock, any select code can be written regardless of the strap level, including 4'b0000 after a strap reset of 4'b0011.
- R8: The tick output is high for one cycle out of every N cycles, where N is 2 raised to the select code for codes 0 to 8 and N is 256 for codes 9 to 15. For code 0 the tick is high in every cycle.
- R9: An accepted select write restarts the divide counter. When the write is sampled at edge E, the first tick at the new rate appears in the cycle after edge E+N-1, that is, N-1 cycles after the cycle that follows E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_div8 | input | 1 | Reset-time strap: 1 selects divide by eight, 0 selects divide by one |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data: flag, reserved zeros, select code |
| tick | output | 1 | Clock-enable pulse at the divided rate |

## Verification
The hardest situations to reach are the edges of the four-cycle window: a select write that lands exactly on the last accepted edge, a write one edge too late, and a repeated unlock in the middle of the window, which must not lengthen it. The stimulus reaches these by counting idle edges after the unlocking write, so the second write falls on the chosen edge. The bench then reads the register back and times the first tick after the change to confirm that the counter restarted.

// File: rtl/pclk_pkg.sv
// Package: shared constants and decode helpers for the protected clock prescaler.
// Assumes an 8-bit register with the change-enable flag in the top bit.
package pclk_pkg;
    localparam int REG_W  = 8;
    localparam int FLAG_B = REG_W - 1;

    // Recognise the unlock pattern: flag bit alone set.
    function automatic logic is_unlock(input logic [REG_W-1:0] d);
        return d == {1'b1, {(REG_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/pclk_unlock.sv
// Module: change-enable flag with a self-expiring window.
// Assumes writes are single-cycle strobes; a flag-clear write ends the window early.
module pclk_unlock #(
    parameter int WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       en_o
);
    import pclk_pkg::*;

    localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [TW-1:0] left_q;
    logic          unlock_wr;
    logic          sel_wr;

    // Decode the two kinds of write that matter here.
    always_comb begin
        unlock_wr = wr_en && is_unlock(wr_data);
        sel_wr    = wr_en && !wr_data[FLAG_B];
    end

    // Open the window on unlock; close on timeout or on a select write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            left_q <= '0;
        end else if (!en_o) begin
            if (unlock_wr) begin
                en_o   <= 1'b1;
                left_q <= TW'(WINDOW - 1);
            end
        end else if (sel_wr || left_q == '0) begin
            en_o <= 1'b0;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end

    // Checker state: consecutive cycles the flag has been high.
    logic [TW:0] held_q;
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= en_o ? held_q + 1'b1 : '0;
    end

    // R2
    unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> $past(wr_en && is_unlock(wr_data)));
    // R3
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> (held_q < (TW+1)'(WINDOW)));
    // R4
    window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && held_q == (TW+1)'(WINDOW - 1)) |=> !en_o);
endmodule

// File: rtl/pclk_sel_reg.sv
// Module: divide select register with strap-dependent reset value.
// Assumes en_i is the change-enable flag; writes outside its window are dropped.
module pclk_sel_reg #(
    parameter int SEL_W     = 4,
    parameter int STRAP_SEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_i,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             en_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             chg_o
);
    import pclk_pkg::*;

    // An accepted select write: window open, flag bit written as zero.
    always_comb chg_o = wr_en && !wr_data[FLAG_B] && en_i;

    // Load the strap default at reset, otherwise take accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_o <= strap_i ? SEL_W'(STRAP_SEL) : '0;
        else if (chg_o) sel_o <= wr_data[SEL_W-1:0];
    end

    // R5
    sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_o) |-> $past(en_i && wr_en && !wr_data[FLAG_B]));
endmodule

// File: rtl/pclk_tick_gen.sv
// Module: power-of-two divider producing a one-cycle enable pulse.
// Assumes codes above MAX_EXP clamp to MAX_EXP; restart_i zeroes the count.
module pclk_tick_gen #(
    parameter int SEL_W   = 4,
    parameter int MAX_EXP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             restart_i,
    output logic             tick_o
);
    localparam int CW = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [SEL_W-1:0] exp_c;
    logic [CW:0]      pow_c;
    logic [CW-1:0]    limit_c;
    logic [CW-1:0]    cnt_q;

    // Clamp the code and derive the terminal count N-1.
    always_comb begin
        exp_c   = (sel_i > SEL_W'(MAX_EXP)) ? SEL_W'(MAX_EXP) : sel_i;
        pow_c   = (CW+1)'(1) << exp_c;
        limit_c = pow_c[CW-1:0] - CW'(1);
        tick_o  = (cnt_q == limit_c);
    end

    // Count cycles, wrapping on the pulse and zeroing on a new setting.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else if (tick_o)         cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // R9
    restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(restart_i) && limit_c != '0) |-> !tick_o);
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && limit_c != '0 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/pclk_guard_div.sv
// Module: top of the protected-write clock prescaler.
// Assumes the bus master issues unlock then select within the window.
module pclk_guard_div #(
    parameter int SEL_W     = 4,
    parameter int MAX_EXP   = 8,
    parameter int WINDOW    = 4,
    parameter int STRAP_SEL = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_div8,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       tick
);
    import pclk_pkg::*;

    localparam int RSV_W = REG_W - 1 - SEL_W;

    logic             en_w;
    logic             chg_w;
    logic [SEL_W-1:0] sel_w;

    pclk_unlock #(.WINDOW(WINDOW)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .en_o(en_w)
    );

    pclk_sel_reg #(.SEL_W(SEL_W), .STRAP_SEL(STRAP_SEL)) u_sel (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_div8), .wr_en(wr_en),
        .wr_data(wr_data), .en_i(en_w), .sel_o(sel_w), .chg_o(chg_w)
    );

    pclk_tick_gen #(.SEL_W(SEL_W), .MAX_EXP(MAX_EXP)) u_tick (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_w), .restart_i(chg_w), .tick_o(tick)
    );

    // Assemble read data; reserved field exists only when the select is narrow.
    generate
        if (RSV_W > 0) begin : g_rsv
            always_comb rd_data = {en_w, {RSV_W{1'b0}}, sel_w};
        end else begin : g_norsv
            always_comb rd_data = {en_w, sel_w};
        end
    endgenerate

    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:4] == 3'b000);
endmodule

// File: tb/pclk_guard_div_tb.sv
`timescale 1ns/100ps
module pclk_guard_div_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_div8 = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pclk_guard_div u_dut (
        .clk(clk), .rst_n(rst_n), .strap_div8(strap_div8),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected register values and compare mid-cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check(it.tag, int'(rd_data), int'(it.val));
        end
    end

    // Driver: queue an expected read value, let the monitor consume it.
    task automatic expect_rd(input string tag, input logic [7:0] v);
        exp_t it;
        it.tag = tag;
        it.val = v;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    // One write strobe, sampled at the next rising edge.
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Distance between consecutive ticks, in cycles.
    task automatic period_chk(input string tag, input int exp);
        int n;
        @(negedge clk);
        while (!tick) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick);
        check(tag, n, exp);
    endtask

    // Cycles from the one after an accepted write until the first tick.
    task automatic first_chk(input string tag, input int exp);
        int k;
        k = 0;
        @(negedge clk);
        while (!tick) begin k++; @(negedge clk); end
        check(tag, k, exp);
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0;
        strap_div8 = s;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        do_reset(1'b1);
        expect_rd("R6 strap high reset", 8'h03);
        period_chk("R8 divide by 8", 8);

        wr(8'h05);
        expect_rd("R5 write while locked", 8'h03);
        wr(8'h81);
        expect_rd("R2 unlock with extra bit", 8'h03);
        wr(8'hC0);
        expect_rd("R2 unlock with reserved bit", 8'h03);

        // Repeat unlock inside the window: no clear, no restart.
        wr(8'h80);
        expect_rd("R1 flag visible", 8'h83);
        idle(1);
        wr(8'h80);
        expect_rd("R4 rewrite keeps flag", 8'h83);
        idle(1);
        expect_rd("R4 still open at k+3", 8'h83);
        idle(1);
        expect_rd("R4 no restart, closed at k+4", 8'h03);

        // Last accepted edge k+4, reserved bits ignored.
        wr(8'h80);
        expect_rd("R3 open after unlock", 8'h83);
        idle(3);
        expect_rd("R3 open at k+3", 8'h83);
        wr(8'h76);
        first_chk("R9 restart divide by 64", 63);
        expect_rd("R5 accepted, reserved ignored", 8'h06);
        period_chk("R8 divide by 64", 64);

        // One edge too late.
        wr(8'h80);
        idle(4);
        wr(8'h02);
        expect_rd("R3 late write rejected", 8'h06);

        wr(8'h80);
        wr(8'h00);
        expect_rd("R7 zero after strap reset", 8'h00);
        period_chk("R8 divide by 1", 1);

        wr(8'h80);
        wr(8'h08);
        expect_rd("R5 code 8", 8'h08);
        period_chk("R8 code 8", 256);

        wr(8'h80);
        wr(8'h0B);
        first_chk("R9 restart code 11", 255);
        period_chk("R8 code 11 clamps", 256);

        wr(8'h80);
        wr(8'h02);
        first_chk("R9 restart divide by 4", 3);
        period_chk("R8 divide by 4", 4);

        do_reset(1'b0);
        expect_rd("R6 strap low reset", 8'h00);
        period_chk("R6 strap low divide by 1", 1);

        wr(8'h80);
        wr(8'h03);
        expect_rd("R7 write after low strap", 8'h03);

        done = 1;
        finish_run();
    end
endmodule